// File: doc/BRIEF.md
# Section Descrambler with B1 Parity Monitor

This block sits in the receive path of one SONET STS-N channel, after the framer. It takes one 32-bit word per clock, with a frame pulse on the first word of each frame, and returns the descrambled word one clock later. The section overhead bytes at the start of the frame (the A1 group, the A2 group and the J0 group, 3N bytes) pass unchanged. All later bytes are XORed with the frame-synchronous keystream of the generator 1 + x^6 + x^7. A control input turns descrambling off, and the words then pass unchanged.

While descrambling, the block builds the section BIP-8 from the line stream as received. This is the XOR of every byte of a frame. At the start of the next frame it holds that value and compares it with that frame's B1 byte, taken after descrambling. A mismatch gives a one-clock error pulse and sets a sticky alarm. The number of mismatched bits is added to a saturating error counter. A clear input resets both the alarm and the counter.

A five-state machine follows the frame position. `ST_IDLE` waits for the first frame pulse and goes to `ST_HDR_FIRST` when the pulse arrives. `ST_HDR_FIRST` goes to `ST_BODY_FIRST` at the first scrambled word. The next frame start, from either first-frame state, goes to `ST_HDR`. `ST_HDR` goes to `ST_BODY` at the first scrambled word. Any frame start returns `ST_HDR` or `ST_BODY` to `ST_HDR`. The B1 check runs only in `ST_BODY`, because only then does a full preceding frame exist.

Top module: `sts_descrambler_b1`

## Requirements
- R1: While rst_n is low and after reset, out_word, out_fp, b1_err, b1_alarm and b1_err_count are all zero.
- R2: out_word and out_fp follow in_word and in_fp with a latency of exactly one clock, and out_fp is high only on the word that entered with in_fp high.
- R3: Words before the first frame pulse, and the first 3N/4 words of each frame (word positions 0 to 3N/4-1, which hold the A1, A2 and J0 groups), leave the block unchanged.
- R4: Every word from position 3N/4 to the end of the frame is XORed with the keystream. The keystream comes from a 7-bit register g, loaded with 7'h7F at word 3N/4. For each bit, the key bit is g[6] and g then becomes {g[5:0], g[6]^g[5]}. In each word, bit 31 takes the first key bit.
- R5: When dscr_off is high, the output word equals the input word at every position.
- R6: The word position is 0 on a word with in_fp high and otherwise rises by one each clock. After position 810N/4-1 it wraps to 0 on its own, and the wrap counts as a frame start even without a pulse.
- R7: The BIP-8 of a frame is the XOR of all four bytes of every word of that frame, taken as received before descrambling and including the overhead bytes.
- R8: The B1 byte is bits 31:24 of word 90N/4, after descrambling. When its frame follows a complete frame, it is compared with that frame's BIP-8, and b1_err is high for one clock, together with the output of that word, if they differ. No check is made in the first frame after the first frame pulse.
- R9: On each mismatch, b1_err_count grows by the number of differing bits and holds at its maximum value 2^CNT_W-1.
- R10: b1_alarm is set by a mismatch and stays set. When err_clr is high, the counter and the alarm are cleared at the next edge, and the clear wins over a mismatch in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 32 | Received word, first line byte in bits 31:24 |
| in_fp | input | 1 | High on word 0 of a frame |
| dscr_off | input | 1 | Pass words without descrambling |
| err_clr | input | 1 | Clear the error counter and the alarm |
| out_word | output | 32 | Descrambled word, one clock after input |
| out_fp | output | 1 | Frame pulse aligned with out_word |
| b1_err | output | 1 | One-clock pulse on a B1 mismatch |
| b1_alarm | output | 1 | Sticky B1 mismatch alarm |
| b1_err_count | output | CNT_W | Saturating count of mismatched B1 bits |

## Verification
The assertions assume a steady stream of one word per clock, with in_fp either aligned to the flywheel position or starting a fresh frame. They also assume err_clr and dscr_off are sampled only on clock edges. The stimulus keeps to this: the bench drives every input on the falling edge from a single model, and it places pulses only on word 0 of full-length frames, except for one frame that tests the flywheel wrap. To get frames whose B1 matches, the model writes into the B1 slot the value it predicts, XORed with the expected keystream byte. It then flips chosen bit masks there to produce known mismatch counts, with descrambling both on and off.

// File: rtl/stsd_pkg.sv
package stsd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_FIRST,
        ST_BODY_FIRST,
        ST_HDR,
        ST_BODY
    } frame_st_t;

    localparam int WORD_W = 32;
    localparam int LFSR_W = 7;

    function automatic logic [7:0] fold_bytes(input logic [WORD_W-1:0] w);
        return w[31:24] ^ w[23:16] ^ w[15:8] ^ w[7:0];
    endfunction

    function automatic logic [3:0] ones8(input logic [7:0] b);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'b000, b[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/stsd_frame_fsm.sv
module stsd_frame_fsm
    import stsd_pkg::*;
#(
    parameter int N_STS = 48,
    localparam int WORDS = 810 * N_STS / 4,
    localparam int HDR_W = 3 * N_STS / 4,
    localparam int B1_W  = 90 * N_STS / 4,
    localparam int POS_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fp,
    output frame_st_t        st_cur,
    output logic [POS_W-1:0] pos_cur,
    output logic             active,
    output logic             body,
    output logic             seed,
    output logic             frame_start,
    output logic             b1_slot
);

    frame_st_t        st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             at_start, at_body;

    always_comb begin
        if (in_fp) begin
            pos_d = '0;
        end else if (st_q == ST_IDLE) begin
            pos_d = pos_q;
        end else if (pos_q == POS_W'(WORDS - 1)) begin
            pos_d = '0;
        end else begin
            pos_d = pos_q + 1'b1;
        end
    end

    assign at_start = (pos_d == '0);
    assign at_body  = (pos_d == POS_W'(HDR_W));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       st_d = in_fp ? ST_HDR_FIRST : ST_IDLE;
            ST_HDR_FIRST:  st_d = at_start ? ST_HDR :
                                  (at_body ? ST_BODY_FIRST : ST_HDR_FIRST);
            ST_BODY_FIRST: st_d = at_start ? ST_HDR : ST_BODY_FIRST;
            ST_HDR:        st_d = at_start ? ST_HDR :
                                  (at_body ? ST_BODY : ST_HDR);
            ST_BODY:       st_d = at_start ? ST_HDR : ST_BODY;
            default:       st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    always_comb begin
        st_cur      = st_d;
        pos_cur     = pos_d;
        active      = (st_d != ST_IDLE);
        body        = (st_d == ST_BODY_FIRST) || (st_d == ST_BODY);
        seed        = body && at_body;
        frame_start = active && at_start;
        b1_slot     = (st_d == ST_BODY) && (pos_d == POS_W'(B1_W));
    end

endmodule

// File: rtl/stsd_keygen.sv
module stsd_keygen
    import stsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              seed,
    output logic [WORD_W-1:0] key
);

    logic [LFSR_W-1:0] g_q, g_n;

    always_comb begin
        logic [LFSR_W-1:0] g;
        g = seed ? {LFSR_W{1'b1}} : g_q;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            key[i] = g[6];
            g      = {g[5:0], g[6] ^ g[5]};
        end
        g_n = g;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= {LFSR_W{1'b1}};
        end else if (run) begin
            g_q <= g_n;
        end
    end

endmodule

// File: rtl/stsd_bip_check.sv
module stsd_bip_check
    import stsd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw_word,
    input  logic [7:0]        b1_byte,
    input  logic              active,
    input  logic              frame_start,
    input  logic              check,
    input  logic              err_clr,
    output logic              b1_err,
    output logic              b1_alarm,
    output logic [CNT_W-1:0]  b1_err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [7:0]     acc_q, bip_prev_q, mism;
    logic [3:0]     nbits;
    logic [CNT_W:0] sum;
    logic           hit;

    assign mism  = b1_byte ^ bip_prev_q;
    assign nbits = ones8(mism);
    assign hit   = check && (mism != 8'h00);
    assign sum   = {1'b0, b1_err_count} + (CNT_W + 1)'(nbits);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            bip_prev_q <= '0;
        end else if (frame_start) begin
            bip_prev_q <= acc_q;
            acc_q      <= fold_bytes(raw_word);
        end else if (active) begin
            acc_q      <= acc_q ^ fold_bytes(raw_word);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b1_err       <= 1'b0;
            b1_alarm     <= 1'b0;
            b1_err_count <= '0;
        end else begin
            b1_err <= hit;
            if (err_clr) begin
                b1_alarm     <= 1'b0;
                b1_err_count <= '0;
            end else if (hit) begin
                b1_alarm     <= 1'b1;
                b1_err_count <= (sum > {1'b0, CNT_MAX}) ? CNT_MAX : sum[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sts_descrambler_b1.sv
module sts_descrambler_b1
    import stsd_pkg::*;
#(
    parameter int N_STS = 48,
    parameter int CNT_W = 16,
    localparam int WORDS = 810 * N_STS / 4,
    localparam int POS_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      in_word,
    input  logic             in_fp,
    input  logic             dscr_off,
    input  logic             err_clr,
    output logic [31:0]      out_word,
    output logic             out_fp,
    output logic             b1_err,
    output logic             b1_alarm,
    output logic [CNT_W-1:0] b1_err_count
);

    frame_st_t        st_cur;
    logic [POS_W-1:0] pos_cur;
    logic             active, body, seed, frame_start, b1_slot;
    logic [31:0]      key, clear_word;

    stsd_frame_fsm #(.N_STS(N_STS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_fp       (in_fp),
        .st_cur      (st_cur),
        .pos_cur     (pos_cur),
        .active      (active),
        .body        (body),
        .seed        (seed),
        .frame_start (frame_start),
        .b1_slot     (b1_slot)
    );

    stsd_keygen u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (body),
        .seed  (seed),
        .key   (key)
    );

    assign clear_word = (body && !dscr_off) ? (in_word ^ key) : in_word;

    stsd_bip_check #(.CNT_W(CNT_W)) u_bip (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_word     (in_word),
        .b1_byte      (clear_word[31:24]),
        .active       (active),
        .frame_start  (frame_start),
        .check        (b1_slot),
        .err_clr      (err_clr),
        .b1_err       (b1_err),
        .b1_alarm     (b1_alarm),
        .b1_err_count (b1_err_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_fp   <= 1'b0;
        end else begin
            out_word <= clear_word;
            out_fp   <= in_fp;
        end
    end

endmodule

// File: rtl/stsd_checker.sv
module stsd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      in_word,
    input logic             in_fp,
    input logic             dscr_off,
    input logic             err_clr,
    input logic [31:0]      out_word,
    input logic             out_fp,
    input logic             b1_err,
    input logic             b1_alarm,
    input logic [CNT_W-1:0] b1_err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_fp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_fp |=> out_fp);

    assert_fp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_fp |=> !out_fp);

    assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dscr_off |=> (out_word == $past(in_word)));

    assert_err_sets_alarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_err && !$past(err_clr)) |-> b1_alarm);

    assert_count_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (b1_err_count >= $past(b1_err_count)));

    assert_count_holds_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clr && b1_err_count == CNT_MAX) |=> (b1_err_count == CNT_MAX));

    assert_alarm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_alarm && !err_clr) |=> b1_alarm);

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (!b1_alarm && b1_err_count == '0));

endmodule

bind sts_descrambler_b1 stsd_checker #(.CNT_W(CNT_W)) u_stsd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_word      (in_word),
    .in_fp        (in_fp),
    .dscr_off     (dscr_off),
    .err_clr      (err_clr),
    .out_word     (out_word),
    .out_fp       (out_fp),
    .b1_err       (b1_err),
    .b1_alarm     (b1_alarm),
    .b1_err_count (b1_err_count)
);

// File: tb/tb_sts_descrambler_b1.sv
module tb_sts_descrambler_b1;

    localparam int N     = 4;
    localparam int CW    = 4;
    localparam int WORDS = 810 * N / 4;
    localparam int HDR_W = 3 * N / 4;
    localparam int B1_W  = 90 * N / 4;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   in_word = '0;
    logic          in_fp = 1'b0;
    logic          dscr_off = 1'b0;
    logic          err_clr = 1'b0;
    logic [31:0]   out_word;
    logic          out_fp;
    logic          b1_err;
    logic          b1_alarm;
    logic [CW-1:0] b1_err_count;

    always #4 clk = ~clk;

    sts_descrambler_b1 #(.N_STS(N), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_fp(in_fp),
        .dscr_off(dscr_off), .err_clr(err_clr), .out_word(out_word),
        .out_fp(out_fp), .b1_err(b1_err), .b1_alarm(b1_alarm),
        .b1_err_count(b1_err_count)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    bit          m_started = 0;
    int          m_frame = 0;
    int          m_pos = 0;
    int          m_g = 127;
    int          m_acc = 0;
    int          m_bip_prev = 0;
    int          m_count = 0;
    bit          m_alarm = 0;
    bit [31:0]   e_word = '0;
    bit          e_fp = 0;
    bit          e_err = 0;
    string       e_tag = "R1";

    task automatic check_bit(input string what, input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check_bit("out_word", e_tag, int'(out_word), int'(e_word));
        check_bit("out_fp", "R2", int'(out_fp), int'(e_fp));
        check_bit("b1_err", "R7 R8", int'(b1_err), int'(e_err));
        check_bit("b1_alarm", "R10", int'(b1_alarm), int'(m_alarm));
        check_bit("b1_err_count", "R9", int'(b1_err_count), m_count);
    endtask

    function automatic int fold(input bit [31:0] w);
        return int'(w[31:24] ^ w[23:16] ^ w[15:8] ^ w[7:0]);
    endfunction

    function automatic int popc(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // One word: compare previous expectations, then build and drive the next word.
    task automatic step(input bit fp, input bit off, input bit clr, input bit fix_b1, input int flip);
        bit [31:0] w, key, clear;
        bit        body, chk;
        int        mism;
        @(negedge clk);
        compare_all();
        w = $urandom();
        if (fp) begin
            if (m_started) m_frame++;
            m_started = 1;
            m_pos = 0;
        end else if (m_started) begin
            if (m_pos == WORDS - 1) begin
                m_pos = 0;
                m_frame++;
            end else m_pos++;
        end
        body = m_started && (m_pos >= HDR_W);
        key = '0;
        if (body) begin
            if (m_pos == HDR_W) m_g = 127;
            for (int i = 31; i >= 0; i--) begin
                int b6 = (m_g >> 6) & 1;
                int b5 = (m_g >> 5) & 1;
                key[i] = b6[0];
                m_g = ((m_g << 1) & 127) | (b6 ^ b5);
            end
        end
        if (m_started && m_pos == 0) m_bip_prev = m_acc;
        chk = body && (m_frame >= 1) && (m_pos == B1_W);
        if (m_pos == B1_W && body && fix_b1) begin
            w[31:24] = 8'(m_bip_prev ^ flip) ^ (off ? 8'h00 : key[31:24]);
        end
        clear = (body && !off) ? (w ^ key) : w;
        if (m_started) m_acc = (m_pos == 0) ? fold(w) : (m_acc ^ fold(w));
        mism = chk ? (int'(clear[31:24]) ^ m_bip_prev) : 0;
        e_word = clear;
        e_fp = fp;
        e_err = (mism != 0);
        e_tag = off ? "R5" : (body ? "R4 R6" : "R3");
        if (clr) begin
            m_count = 0;
            m_alarm = 0;
        end else if (mism != 0) begin
            m_alarm = 1;
            m_count = (m_count + popc(mism) > CMAX) ? CMAX : m_count + popc(mism);
        end
        in_word = w;
        in_fp = fp;
        dscr_off = off;
        err_clr = clr;
    endtask

    task automatic run_frame(input bit use_fp, input bit off, input int flip, input int clr_at);
        for (int p = 0; p < WORDS; p++) begin
            step(use_fp && (p == 0), off, (p == clr_at), 1'b1, flip);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check_bit("out_word", "R1", int'(out_word), 0);
        check_bit("b1_alarm", "R1", int'(b1_alarm), 0);
        check_bit("b1_err_count", "R1", int'(b1_err_count), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b0, 1'b0, 0); // R3 idle passthrough
        run_frame(1, 0, 8'h5A, -1);  // R8: first frame never checked
        run_frame(1, 0, 8'h00, -1);  // R8: matching B1, no error
        run_frame(1, 0, 8'h00, -1);
        run_frame(1, 0, 8'h01, -1);  // R9: one bit
        run_frame(1, 0, 8'h07, -1);  // R9: three bits
        run_frame(1, 1, 8'h00, -1);  // R5: descrambler off, matching
        run_frame(1, 1, 8'h10, -1);  // R5 R9
        run_frame(1, 0, 8'h00, 20);  // R10: clear
        run_frame(1, 0, 8'hFF, -1);
        run_frame(1, 0, 8'hFF, -1);  // R9: saturation
        run_frame(1, 0, 8'h03, -1);  // R9: held at max
        run_frame(1, 0, 8'h01, B1_W); // R10: clear beats mismatch
        run_frame(0, 0, 8'h02, -1);  // R6: flywheel wrap without pulse
        run_frame(1, 0, 8'h00, -1);
        @(negedge clk);
        compare_all();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule